// File: doc/BRIEF.md
# Linear Photodiode Array Readout Sequencer

This block drives a self-scanning linear photodiode array from a single system clock. On a frame request it runs the array's internal shift register with two non-overlapping phase clocks. A start pulse is laid over the phase-2 high time of a lead-in clock pair, and one pixel is addressed on each later phase-2 rise. For every pixel the block gives the downstream converter a one-cycle sample strobe. It also pulses the charge-amplifier reset a programmed delay after each phase-2 fall, so that the amplifier is cleared before the next pixel reaches the video line.

All widths are counts of system-clock cycles taken from inputs. Each count is raised to a floor that is set by a parameter: the clock high time, the gap between phases, the reset delay, the reset width and the global reset width. The line ends when the array's active-low end-of-scan pulse arrives, after a two-flop synchronizer. If that pulse never arrives, a timeout ends the line. The spacing between start pulses sets the integration time. While no scan is running, a separate request pulses the saturation-control gate to clear every photodiode at once.

Top module: `lpa_readout_seq`

## Requirements
- R1: `sr_clk_a` and `sr_clk_b` are never high in the same cycle. Every transition between them has max(`gap_cyc`, MIN_GAP) cycles with both low. A value of 0 makes the two clocks complementary.
- R2: Every high period of either clock lasts max(`hi_cyc`, MIN_HI) cycles.
- R3: `start_pulse` rises in the same cycle as the phase-2 rise of the lead-in pair and lasts hi+1 cycles. It therefore overlaps phase 2 for hi cycles and contains exactly one phase-2 falling edge.
- R4: `pix_strobe` is a one-cycle pulse in the first phase-2 high cycle of each of the N pixel pairs that follow the lead-in pair. N is 128 << `pix_sel`, so the codes 0, 1, 2 and 3 give 128, 256, 512 and 1024 pixels.
- R5: During a scan, `integ_reset` rises max(`rst_dly_cyc`, MIN_DLY) cycles after each phase-2 fall and stays high for max(`rst_len_cyc`, 1) cycles. It is never high while phase 2 is high.
- R6: A falling edge on `scan_done_n`, after synchronization, closes the line. The current clock pair completes, the clocks stop, and `busy` falls. A normal line therefore has N+2 phase-2 rises.
- R7: If no end-of-scan arrives by phase-2 rise index N+4 (the lead-in pair is index 0), `timeout` is set and the sequencer returns to idle after N+5 phase-2 rises. The next accepted frame clears `timeout`.
- R8: Two successive start pulses never rise closer together than `period_cyc` cycles. A frame request that comes earlier waits.
- R9: A `grst_req` in idle drives `gate_reset` high for max(`grst_cyc`, MIN_GRST) cycles with all clocks low. A `grst_req` during a scan is ignored.
- R10: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_req | input | 1 | Request one line scan |
| grst_req | input | 1 | Request a global photodiode reset |
| pix_sel | input | 2 | Pixel count code (128 << code) |
| hi_cyc | input | CW | Clock high time in cycles |
| gap_cyc | input | CW | Both-low gap in cycles |
| rst_dly_cyc | input | CW | Phase-2 fall to integrator reset delay |
| rst_len_cyc | input | CW | Integrator reset width |
| grst_cyc | input | CW | Global reset width |
| period_cyc | input | PW | Minimum start-to-start spacing |
| scan_done_n | input | 1 | Active-low end-of-scan from the array |
| start_pulse | output | 1 | Shift-register start pulse |
| sr_clk_a | output | 1 | Phase-1 shift clock |
| sr_clk_b | output | 1 | Phase-2 shift clock |
| integ_reset | output | 1 | Charge-amplifier reset |
| pix_strobe | output | 1 | Per-pixel sample strobe |
| gate_reset | output | 1 | Saturation-control gate pulse |
| busy | output | 1 | Frame, global reset or clock activity in progress |
| timeout | output | 1 | End-of-scan missing on the last line |

## Verification
A wrong pixel index shows at the ports within one pixel pair. The strobe count per line is off, or the phase-2 rise count around the end-of-scan pulse differs from N+2, or a timeout arrives early. A phase counter in the wrong state breaks the high or gap widths at the next clock edge, and the width checks measure those at the ports. A reset timer that is out of step moves the integrator reset relative to the phase-2 fall that precedes it, or makes it overlap phase 2, within the same pixel.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  typedef enum logic [1:0] {PH_A, GAP_AB, PH_B, GAP_BA} phase_t;
  typedef enum logic [1:0] {S_IDLE, S_GRST, S_ARM, S_SCAN} seq_t;

  function automatic logic [10:0] pixels_for(input logic [1:0] code);
    return 11'd128 << code;
  endfunction
endpackage

// File: rtl/lpa_phase_gen.sv
module lpa_phase_gen
  import lpa_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] hi_len,
  input  logic [CW-1:0] gap_len,
  output logic          ph_a,
  output logic          ph_b,
  output logic          b_rise_nx,
  output logic          b_fall_nx,
  output logic          active
);
  phase_t        phase, nxt;
  logic [CW-1:0] cnt, len;
  logic          fin, stop;

  always_comb begin
    len = (phase == PH_A || phase == PH_B) ? hi_len : gap_len;
    fin = ({1'b0, cnt} + 1'b1) >= {1'b0, len};
    case (phase)
      PH_A:    nxt = (gap_len == '0) ? PH_B : GAP_AB;
      GAP_AB:  nxt = PH_B;
      PH_B:    nxt = (gap_len == '0) ? PH_A : GAP_BA;
      default: nxt = PH_A;
    endcase
    stop      = active && fin && (nxt == PH_A) && !run;
    b_rise_nx = active && fin && (nxt == PH_B);
    b_fall_nx = active && fin && (phase == PH_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= PH_A;
      cnt    <= '0;
      ph_a   <= 1'b0;
      ph_b   <= 1'b0;
    end else if (!active) begin
      if (run) begin
        active <= 1'b1;
        phase  <= PH_A;
        cnt    <= '0;
        ph_a   <= 1'b1;
        ph_b   <= 1'b0;
      end
    end else if (fin) begin
      cnt <= '0;
      if (stop) begin
        active <= 1'b0;
        phase  <= PH_A;
        ph_a   <= 1'b0;
        ph_b   <= 1'b0;
      end else begin
        phase <= nxt;
        ph_a  <= (nxt == PH_A);
        ph_b  <= (nxt == PH_B);
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst) !(ph_a && ph_b));
endmodule

// File: rtl/lpa_eos_sync.sv
module lpa_eos_sync (
  input  logic clk,
  input  logic rst,
  input  logic done_n,
  output logic done_fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= done_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign done_fall = s3 && !s2;
endmodule

// File: rtl/lpa_int_reset.sv
module lpa_int_reset #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          b_fall_nx,
  input  logic          b_rise_nx,
  input  logic [CW-1:0] dly,
  input  logic [CW-1:0] len,
  output logic          pulse
);
  logic [CW-1:0] dcnt, n;
  logic          armed, armed_n;
  logic [CW:0]   stop_at;

  always_comb begin
    n       = b_fall_nx ? '0 : ((dcnt == '1) ? dcnt : dcnt + 1'b1);
    armed_n = arm && (b_fall_nx || armed);
    stop_at = {1'b0, dly} + {1'b0, len};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      dcnt  <= '1;
      pulse <= 1'b0;
    end else begin
      armed <= armed_n;
      dcnt  <= n;
      pulse <= armed_n && !b_rise_nx && (n >= dly) && ({1'b0, n} < stop_at);
    end
  end
endmodule

// File: rtl/lpa_readout_seq.sv
module lpa_readout_seq
  import lpa_pkg::*;
#(
  parameter int CW       = 16,
  parameter int PW       = 32,
  parameter int MIN_HI   = 20,
  parameter int MIN_GAP  = 0,
  parameter int MIN_DLY  = 5,
  parameter int MIN_GRST = 501
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_req,
  input  logic          grst_req,
  input  logic [1:0]    pix_sel,
  input  logic [CW-1:0] hi_cyc,
  input  logic [CW-1:0] gap_cyc,
  input  logic [CW-1:0] rst_dly_cyc,
  input  logic [CW-1:0] rst_len_cyc,
  input  logic [CW-1:0] grst_cyc,
  input  logic [PW-1:0] period_cyc,
  input  logic          scan_done_n,
  output logic          start_pulse,
  output logic          sr_clk_a,
  output logic          sr_clk_b,
  output logic          integ_reset,
  output logic          pix_strobe,
  output logic          gate_reset,
  output logic          busy,
  output logic          timeout
);
  localparam int IW = 11;

  logic [CW-1:0] hi_eff, gap_eff, dly_eff, len_eff, grst_eff, gcnt;
  logic [PW-1:0] per_cnt;
  logic [IW-1:0] idx, npix;
  seq_t          state;
  logic          run, gen_busy, rise_nx, fall_nx, done_fall, st_set, st_pend;

  always_comb begin
    hi_eff   = (hi_cyc < CW'(MIN_HI)) ? CW'(MIN_HI) : hi_cyc;
    gap_eff  = (gap_cyc < CW'(MIN_GAP)) ? CW'(MIN_GAP) : gap_cyc;
    dly_eff  = (rst_dly_cyc < CW'(MIN_DLY)) ? CW'(MIN_DLY) : rst_dly_cyc;
    len_eff  = (rst_len_cyc == '0) ? CW'(1) : rst_len_cyc;
    grst_eff = (grst_cyc < CW'(MIN_GRST)) ? CW'(MIN_GRST) : grst_cyc;
    st_set   = (state == S_SCAN) && rise_nx && (idx == '0);
  end

  lpa_phase_gen #(.CW(CW)) u_gen (
    .clk(clk), .rst(rst), .run(run), .hi_len(hi_eff), .gap_len(gap_eff),
    .ph_a(sr_clk_a), .ph_b(sr_clk_b), .b_rise_nx(rise_nx), .b_fall_nx(fall_nx),
    .active(gen_busy)
  );

  lpa_eos_sync u_sync (
    .clk(clk), .rst(rst), .done_n(scan_done_n), .done_fall(done_fall)
  );

  lpa_int_reset #(.CW(CW)) u_irst (
    .clk(clk), .rst(rst), .arm(state == S_SCAN), .b_fall_nx(fall_nx),
    .b_rise_nx(rise_nx), .dly(dly_eff), .len(len_eff), .pulse(integ_reset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      run         <= 1'b0;
      idx         <= '0;
      npix        <= '0;
      start_pulse <= 1'b0;
      st_pend     <= 1'b0;
      pix_strobe  <= 1'b0;
      gate_reset  <= 1'b0;
      gcnt        <= '0;
      per_cnt     <= '1;
      timeout     <= 1'b0;
    end else begin
      per_cnt    <= st_set ? '0 : ((per_cnt == '1) ? per_cnt : per_cnt + 1'b1);
      pix_strobe <= (state == S_SCAN) && rise_nx && (idx != '0) && (idx <= npix);
      st_pend    <= fall_nx && start_pulse;
      if (st_set)       start_pulse <= 1'b1;
      else if (st_pend) start_pulse <= 1'b0;

      case (state)
        S_IDLE: if (!gen_busy) begin
          if (grst_req) begin
            gate_reset <= 1'b1;
            gcnt       <= CW'(1);
            state      <= S_GRST;
          end else if (frame_req) begin
            state <= S_ARM;
          end
        end
        S_GRST: begin
          if (gcnt >= grst_eff) begin
            gate_reset <= 1'b0;
            state      <= S_IDLE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_ARM: if (!gen_busy && per_cnt >= period_cyc) begin
          run     <= 1'b1;
          idx     <= '0;
          npix    <= pixels_for(pix_sel);
          timeout <= 1'b0;
          state   <= S_SCAN;
        end
        default: begin
          if (done_fall) begin
            run   <= 1'b0;
            state <= S_IDLE;
          end else if (rise_nx) begin
            if (idx == npix + IW'(4)) begin
              timeout <= 1'b1;
              run     <= 1'b0;
              state   <= S_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy = (state != S_IDLE) || gen_busy;

  a_r4_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
    pix_strobe |-> (sr_clk_b && !$past(sr_clk_b)));
  a_r5_reset_clear_of_b: assert property (@(posedge clk) disable iff (rst)
    integ_reset |-> !sr_clk_b);
  a_r9_gate_outside_scan: assert property (@(posedge clk) disable iff (rst)
    gate_reset |-> (!sr_clk_a && !sr_clk_b && !start_pulse));
  a_r3_start_with_b: assert property (@(posedge clk) disable iff (rst)
    $rose(start_pulse) |-> $rose(sr_clk_b));
endmodule

// File: tb/lpa_readout_seq_bench.sv
module lpa_readout_seq_bench;
  localparam int CW = 16;
  localparam int PW = 32;
  localparam int NV = 4;
  // sel, hi, gap, dly, len, exp_n, exp_hi, exp_gap, exp_dly, exp_len
  localparam int VT [NV][10] = '{
    '{0, 20, 0, 5, 4,  128, 20, 0, 5, 4},
    '{0, 10, 3, 2, 0,  128, 20, 3, 5, 1},
    '{1, 25, 5, 8, 10, 256, 25, 5, 8, 10},
    '{0, 30, 2, 6, 3,  128, 30, 2, 6, 3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic frame_req = 0, grst_req = 0;
  logic [1:0] pix_sel = 0;
  logic [CW-1:0] hi_cyc = 20, gap_cyc = 0, rst_dly_cyc = 5, rst_len_cyc = 4, grst_cyc = 0;
  logic [PW-1:0] period_cyc = 0;
  logic scan_done_n = 1'b1;
  logic start_pulse, sr_clk_a, sr_clk_b, integ_reset, pix_strobe, gate_reset, busy, timeout;

  lpa_readout_seq u_lpa_readout_seq (
    .clk(clk), .rst(rst), .frame_req(frame_req), .grst_req(grst_req), .pix_sel(pix_sel),
    .hi_cyc(hi_cyc), .gap_cyc(gap_cyc), .rst_dly_cyc(rst_dly_cyc), .rst_len_cyc(rst_len_cyc),
    .grst_cyc(grst_cyc), .period_cyc(period_cyc), .scan_done_n(scan_done_n),
    .start_pulse(start_pulse), .sr_clk_a(sr_clk_a), .sr_clk_b(sr_clk_b),
    .integ_reset(integ_reset), .pix_strobe(pix_strobe), .gate_reset(gate_reset),
    .busy(busy), .timeout(timeout)
  );

  int checks = 0, errors = 0, cyc = 0;
  int ovl, w1, w1mn, w1mx, w2, w2mn, w2mx, g, gmn, gmx;
  int sw, swl, sov, sfall, ns, bad_s, nr, c, dmn, dmx, wr, wrmn, wrmx, bad_r;
  int wg, wgl, ng, bad_g, last_st, st_int, pos, npix_m;
  bit eos_en = 1'b1;
  logic p1q = 0, p2q = 0, stq = 0, irq = 0, sgq = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic clr();
    ovl = 0; w1 = 0; w2 = 0; g = 0; sw = 0; swl = 0; sov = 0; sfall = 0;
    ns = 0; bad_s = 0; nr = 0; wr = 0; bad_r = 0; wg = 0; wgl = 0; ng = 0; bad_g = 0;
    w1mn = 1 << 30; w2mn = 1 << 30; gmn = 1 << 30; dmn = 1 << 30; wrmn = 1 << 30;
    w1mx = 0; w2mx = 0; gmx = 0; dmx = 0; wrmx = 0;
  endtask

  always @(negedge clk) begin
    if (sr_clk_a && sr_clk_b) ovl++;
    if (sr_clk_a) begin w1++; g = 0; end
    else if (p1q) begin
      if (w1 < w1mn) w1mn = w1;
      if (w1 > w1mx) w1mx = w1;
      w1 = 0;
    end
    if (!sr_clk_a && !sr_clk_b) g++;
    if (sr_clk_b) w2++;
    if (sr_clk_b && !p2q) begin
      nr++;
      if (g < gmn) gmn = g;
      if (g > gmx) gmx = g;
      if (start_pulse) pos = 0; else pos++;
    end
    if (!sr_clk_b && p2q) begin
      if (w2 < w2mn) w2mn = w2;
      if (w2 > w2mx) w2mx = w2;
      w2 = 0;
      c = 0;
    end else c++;
    if (start_pulse) begin
      sw++;
      if (sr_clk_b) sov++;
      if (!sr_clk_b && p2q) sfall++;
      if (!stq) begin st_int = cyc - last_st; last_st = cyc; end
    end else if (stq) begin swl = sw; sw = 0; end
    if (pix_strobe) begin
      ns++;
      if (!(sr_clk_b && !p2q)) bad_s++;
    end
    if (integ_reset) begin
      wr++;
      if (sr_clk_b) bad_r++;
      if (!irq) begin
        if (c < dmn) dmn = c;
        if (c > dmx) dmx = c;
      end
    end else if (irq) begin
      if (wr < wrmn) wrmn = wr;
      if (wr > wrmx) wrmx = wr;
      wr = 0;
    end
    if (gate_reset) begin
      wg++;
      if (!sgq) ng++;
      if (sr_clk_a || sr_clk_b || start_pulse) bad_g++;
    end else if (sgq) begin wgl = wg; wg = 0; end
    scan_done_n = !(eos_en && sr_clk_b && pos == npix_m + 1);
    p1q = sr_clk_a; p2q = sr_clk_b; stq = start_pulse; irq = integ_reset; sgq = gate_reset;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    repeat (3) @(posedge clk);
    while (busy) @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input int sel, hi, gp, dl, ln, per, input bit eos_on);
    pix_sel = 2'(sel); hi_cyc = CW'(hi); gap_cyc = CW'(gp);
    rst_dly_cyc = CW'(dl); rst_len_cyc = CW'(ln); period_cyc = PW'(per);
    npix_m = 128 << sel; eos_en = eos_on;
    @(posedge clk); #1;
    clr();
    frame_req = 1'b1;
    @(posedge clk); #1;
    frame_req = 1'b0;
    wait_idle();
  endtask

  initial begin
    wait (cyc > 190000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pos = 1 << 20; last_st = 0; st_int = 0; npix_m = 128;
    clr();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R10: quiet outputs after reset
    chk("R10 outputs", {start_pulse, sr_clk_a, sr_clk_b, integ_reset, pix_strobe,
                        gate_reset, busy, timeout}, 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4], 0, 1'b1);
      chk("R1 overlap", ovl, 0);
      chk("R1 gap min", gmn, VT[v][7]);
      chk("R1 gap max", gmx, VT[v][7]);
      chk("R2 phase1 min", w1mn, VT[v][6]);
      chk("R2 phase1 max", w1mx, VT[v][6]);
      chk("R2 phase2 min", w2mn, VT[v][6]);
      chk("R2 phase2 max", w2mx, VT[v][6]);
      chk("R3 start width", swl, VT[v][6] + 1);
      chk("R3 overlap", sov, VT[v][6]);
      chk("R3 falls inside", sfall, 1);
      chk("R4 strobes", ns, VT[v][5]);
      chk("R4 strobe position", bad_s, 0);
      chk("R5 delay min", dmn, VT[v][8]);
      chk("R5 delay max", dmx, VT[v][8]);
      chk("R5 width min", wrmn, VT[v][9]);
      chk("R5 width max", wrmx, VT[v][9]);
      chk("R5 clear of phase2", bad_r, 0);
      chk("R6 phase2 rises", nr, VT[v][5] + 2);
      chk("R6 busy", busy, 0);
      chk("R7 no timeout", timeout, 0);
    end

    // R7: missing end-of-scan
    run_frame(0, 20, 0, 5, 4, 0, 1'b0);
    chk("R7 timeout set", timeout, 1);
    chk("R7 phase2 rises", nr, 128 + 5);
    chk("R7 strobes", ns, 128);
    chk("R7 busy", busy, 0);
    run_frame(0, 20, 0, 5, 4, 0, 1'b1);
    chk("R7 timeout cleared", timeout, 0);
    chk("R6 rises after recovery", nr, 130);

    // R8: start-to-start spacing
    run_frame(0, 20, 0, 5, 4, 9000, 1'b1);
    run_frame(0, 20, 0, 5, 4, 9000, 1'b1);
    checks++;
    if (st_int < 9000 || st_int > 9024) begin
      errors++;
      $display("FAIL R8 interval actual %0d expected %0d", st_int, 9022);
    end

    // R9: global reset widths, clamped and unclamped
    grst_cyc = CW'(100);
    @(posedge clk); #1; clr();
    grst_req = 1'b1; @(posedge clk); #1; grst_req = 1'b0;
    wait_idle();
    chk("R9 clamped width", wgl, 501);
    grst_cyc = CW'(600);
    @(posedge clk); #1; clr();
    grst_req = 1'b1; @(posedge clk); #1; grst_req = 1'b0;
    wait_idle();
    chk("R9 width", wgl, 600);
    chk("R9 clocks quiet", bad_g, 0);

    // R9: request during a scan is ignored
    period_cyc = 0;
    @(posedge clk); #1; clr();
    frame_req = 1'b1; @(posedge clk); #1; frame_req = 1'b0;
    repeat (600) @(posedge clk);
    #1 grst_req = 1'b1; @(posedge clk); #1; grst_req = 1'b0;
    wait_idle();
    chk("R9 ignored in scan", ng, 0);
    chk("R9 scan intact", ns, 128);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule